// File: doc/BRIEF.md
# Boot ROM Slave with Power-Up Vector Redirect

This block is a read-only bus slave on an 18-bit-address, 16-bit-data system bus. It answers for a 512-word constant store, split into two 256-word windows: one at octal 765000–765777 and one at octal 773000–773777. It also answers for a switch register at octal 773024, which returns the boot-select switches shifted left by one, so the value is always even and can serve as a start address.

Its main duty is at power-up. If redirect is enabled when the init line falls, the processor's next two vector fetches are served from the high window instead of from low memory. The fetch of octal 000024 (start PC) and the fetch of octal 000026 (start PSW) are both served this way. The target pair is octal 773024/773026, or octal 773224/773226 when the alternate-vector input is set. Once the PSW fetch has been answered, the low vector addresses are released. If redirect is disabled, the block never claims them. A disable input removes the low window, so that peripherals there do not clash with the store.

Top module: `bootrom_slave`

## Requirements
- R1: While reset is held, and on its release, `bus_ack` and `bus_rdata` are 0. While `bus_init` is high, octal address 000024 receives no acknowledge.
- R2: Store word i holds ((i*40503) mod 65536) XOR 16'h5A5A. A read of the low window returns word (A-765000)/2, and a read of the high window returns word 256+(A-773000)/2, where A is the address with bit 0 cleared. The values are octal, and address bit 0 is ignored.
- R3: A read of octal 773024 returns the switch register. Bits 9:1 hold `cfg_sw[8:0]`, and bit 0 and bits 15:10 read 0. This holds whether or not a redirect is pending.
- R4: While `cfg_lo_off` is 1, no address from octal 765000 through 765777 is acknowledged.
- R5: `bus_ack` rises on the first clock edge at which a strobe (`bus_rd` or `bus_wr`) is seen with a decoded address. It stays high while the strobe stays high, and falls on the first edge at which the strobe is seen low. An undecoded address is never acknowledged, and the read data stays constant while `bus_ack` is held.
- R6: A write to a decoded address is acknowledged like a read and changes nothing: a later read returns the same data.
- R7: Redirect is armed on the clock edge where `bus_init` is first seen low, if `cfg_boot_sw` OR `cfg_boot_ext` is 1. While armed, reads of octal 000024 and 000026 return store words 266 and 267. If `cfg_alt_vec` is 1, they return words 330 and 331 instead.
- R8: If neither enable is set when `bus_init` falls, octal 000024 and 000026 are never acknowledged.
- R9: Once the read of octal 000026 has been acknowledged, redirect ends. After that, octal 000024 is no longer acknowledged.
- R10: Raising `bus_init` cancels a pending redirect. The next fall of `bus_init` arms it again according to R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_init | input | 1 | Power-fail/init, high while the system initialises |
| bus_addr | input | 18 | Byte address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe (data ignored) |
| bus_rdata | output | 16 | Read data, valid while bus_ack is high |
| bus_ack | output | 1 | Slave acknowledge |
| cfg_boot_sw | input | 1 | On-board redirect enable switch |
| cfg_boot_ext | input | 1 | External redirect enable line |
| cfg_lo_off | input | 1 | Disable the low store window |
| cfg_alt_vec | input | 1 | Select the alternate redirect target |
| cfg_sw | input | 9 | Boot-select switches |

## Verification
A wrong redirect flag shows up at the ports within one bus cycle of the next vector fetch. Either octal 000024 gets an acknowledge it should not get, or it gets none, or the PC/PSW data comes from the wrong target pair. A miscomputed store index or window match shows on the first read of the affected address, so every word of both windows is read in turn, with bit 0 set on alternate reads. A flaw in the acknowledge hold logic shows as an acknowledge that drops while the strobe is still high. The read of octal 000026, which also clears the redirect flag, is watched for exactly this.

// File: rtl/bootrom_pkg.sv
package bootrom_pkg;
   localparam logic [17:0] LO_BASE  = 18'o765000;
   localparam logic [17:0] HI_BASE  = 18'o773000;
   localparam logic [17:0] SW_ADDR  = 18'o773024;
   localparam logic [17:0] PC_VEC   = 18'o000024;
   localparam logic [17:0] PSW_VEC  = 18'o000026;
   localparam logic [17:0] TGT_MAIN = 18'o773024;
   localparam logic [17:0] TGT_ALT  = 18'o773224;

   typedef enum logic [1:0] {
      HIT_NONE = 2'd0,
      HIT_ROM  = 2'd1,
      HIT_SW   = 2'd2
   } hit_kind_e;

   function automatic logic [15:0] rom_seed(int unsigned i);
      logic [31:0] p;
      p = i * 32'd40503;
      return p[15:0] ^ 16'h5A5A;
   endfunction
endpackage

// File: rtl/bootrom_store.sv
module bootrom_store
   import bootrom_pkg::*;
#(
   parameter int ROM_WORDS = 512,
   parameter int DATA_W    = 16,
   localparam int IDX_W    = $clog2(ROM_WORDS)
) (
   input  logic [IDX_W-1:0]  idx,
   output logic [DATA_W-1:0] word
);
   logic [DATA_W-1:0] mem [ROM_WORDS];

   if (DATA_W != 16) begin : g_bad_width
      $error("bootrom_store: DATA_W must be 16");
   end

   for (genvar g = 0; g < ROM_WORDS; g++) begin : g_init
      assign mem[g] = rom_seed(g);
   end

   assign word = mem[idx];
endmodule

// File: rtl/bootrom_decode.sv
module bootrom_decode
   import bootrom_pkg::*;
#(
   parameter int ADDR_W    = 18,
   parameter int ROM_WORDS = 512,
   parameter bit LO_WINDOW = 1'b1,
   localparam int IDX_W    = $clog2(ROM_WORDS),
   localparam int HALF     = ROM_WORDS / 2,
   localparam int WIN_LSB  = $clog2(HALF) + 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              armed,
   input  logic              alt_vec,
   input  logic              lo_off,
   output hit_kind_e         kind,
   output logic [IDX_W-1:0]  idx,
   output logic              is_psw
);
   logic [ADDR_W-1:0] wa;
   logic              in_hi, in_lo, is_pc;
   logic [ADDR_W-1:0] tgt, dt;

   assign wa     = {addr[ADDR_W-1:1], 1'b0};
   assign in_hi  = (wa[ADDR_W-1:WIN_LSB] == HI_BASE[ADDR_W-1:WIN_LSB]);
   assign is_pc  = (wa == PC_VEC);
   assign is_psw = (wa == PSW_VEC);

   if (LO_WINDOW) begin : g_lo
      assign in_lo = !lo_off && (wa[ADDR_W-1:WIN_LSB] == LO_BASE[ADDR_W-1:WIN_LSB]);
   end else begin : g_no_lo
      assign in_lo = 1'b0;
   end

   always_comb begin
      tgt  = (alt_vec ? TGT_ALT : TGT_MAIN) + (is_psw ? ADDR_W'(2) : ADDR_W'(0));
      dt   = tgt - HI_BASE;
      kind = HIT_NONE;
      idx  = '0;
      if (armed && (is_pc || is_psw)) begin
         kind = HIT_ROM;
         idx  = {1'b1, dt[WIN_LSB-1:1]};
      end else if (wa == SW_ADDR) begin
         kind = HIT_SW;
      end else if (in_hi) begin
         kind = HIT_ROM;
         idx  = {1'b1, wa[WIN_LSB-1:1]};
      end else if (in_lo) begin
         kind = HIT_ROM;
         idx  = {1'b0, wa[WIN_LSB-1:1]};
      end
   end
endmodule

// File: rtl/bootrom_vector_ctl.sv
module bootrom_vector_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_init,
   input  logic en_sw,
   input  logic en_ext,
   input  logic psw_fetch,
   output logic armed
);
   logic init_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_q <= 1'b1;
         armed  <= 1'b0;
      end else begin
         init_q <= bus_init;
         if (bus_init)
            armed <= 1'b0;
         else if (init_q)
            armed <= en_sw | en_ext;
         else if (psw_fetch)
            armed <= 1'b0;
      end
   end

   // R10
   init_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_init |=> !armed);
   // R7
   arm_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed) |-> $past(en_sw || en_ext));
   // R9
   disarm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(armed) |-> $past(bus_init || psw_fetch));
endmodule

// File: rtl/bootrom_slave.sv
module bootrom_slave
   import bootrom_pkg::*;
#(
   parameter int ADDR_W    = 18,
   parameter int DATA_W    = 16,
   parameter int ROM_WORDS = 512,
   parameter int SW_BITS   = 9,
   parameter bit LO_WINDOW = 1'b1,
   localparam int IDX_W    = $clog2(ROM_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_init,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_ack,
   input  logic              cfg_boot_sw,
   input  logic              cfg_boot_ext,
   input  logic              cfg_lo_off,
   input  logic              cfg_alt_vec,
   input  logic [SW_BITS-1:0] cfg_sw
);
   if (ADDR_W != 18) begin : g_bad_addr
      $error("bootrom_slave: ADDR_W must be 18");
   end
   if (ROM_WORDS != 512) begin : g_bad_depth
      $error("bootrom_slave: ROM_WORDS must be 512");
   end
   if (SW_BITS < 1 || SW_BITS >= DATA_W) begin : g_bad_sw
      $error("bootrom_slave: SW_BITS out of range");
   end

   hit_kind_e         kind;
   logic [IDX_W-1:0]  idx;
   logic              is_psw, armed, strobe, hit;
   logic [DATA_W-1:0] rom_q, sw_word;

   assign strobe = bus_rd | bus_wr;
   assign hit    = (kind != HIT_NONE);

   for (genvar g = 0; g < DATA_W; g++) begin : g_sw
      if (g >= 1 && g <= SW_BITS) begin : g_bit
         assign sw_word[g] = cfg_sw[g-1];
      end else begin : g_zero
         assign sw_word[g] = 1'b0;
      end
   end

   bootrom_decode #(.ADDR_W(ADDR_W), .ROM_WORDS(ROM_WORDS), .LO_WINDOW(LO_WINDOW)) u_dec (
      .addr(bus_addr), .armed(armed), .alt_vec(cfg_alt_vec), .lo_off(cfg_lo_off),
      .kind(kind), .idx(idx), .is_psw(is_psw)
   );

   bootrom_store #(.ROM_WORDS(ROM_WORDS), .DATA_W(DATA_W)) u_store (
      .idx(idx), .word(rom_q)
   );

   bootrom_vector_ctl u_vec (
      .clk(clk), .rst_n(rst_n), .bus_init(bus_init),
      .en_sw(cfg_boot_sw), .en_ext(cfg_boot_ext),
      .psw_fetch(armed && bus_rd && !bus_ack && is_psw),
      .armed(armed)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_ack   <= 1'b0;
         bus_rdata <= '0;
      end else begin
         bus_ack <= strobe && (hit || bus_ack);
         if (!strobe)
            bus_rdata <= '0;
         else if (!bus_ack && hit && bus_rd)
            bus_rdata <= (kind == HIT_SW) ? sw_word : rom_q;
      end
   end

   // R5
   ack_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_ack) |-> $past(strobe));
   // R5
   ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |=> !bus_ack);
   // R5
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_ack && $past(bus_ack)) |-> $stable(bus_rdata));
   // R4
   lo_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_lo_off && strobe && !bus_ack && bus_addr[17:9] == LO_BASE[17:9]) |=> !bus_ack);
   // R3
   sw_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_ack && {bus_addr[17:1], 1'b0} == SW_ADDR) |=> (bus_rdata[0] == 1'b0));
endmodule

// File: tb/bootrom_slave_bench.sv
module bootrom_slave_bench;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_init = 1'b1;
   logic [17:0] bus_addr = '0;
   logic        bus_rd = 1'b0, bus_wr = 1'b0;
   logic [15:0] bus_rdata;
   logic        bus_ack;
   logic        cfg_boot_sw = 1'b0, cfg_boot_ext = 1'b0, cfg_lo_off = 1'b0, cfg_alt_vec = 1'b0;
   logic [8:0]  cfg_sw = '0;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bootrom_slave u_bootrom_slave (
      .clk(clk), .rst_n(rst_n), .bus_init(bus_init), .bus_addr(bus_addr),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
      .cfg_boot_sw(cfg_boot_sw), .cfg_boot_ext(cfg_boot_ext), .cfg_lo_off(cfg_lo_off),
      .cfg_alt_vec(cfg_alt_vec), .cfg_sw(cfg_sw)
   );

   function automatic logic [15:0] exp_rom(int unsigned i);
      logic [31:0] p;
      p = i * 32'd40503;
      return p[15:0] ^ 16'h5A5A;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic access(string req, logic [17:0] a, bit wr, bit exp_hit, logic [15:0] exp_d);
      @(negedge clk);
      bus_addr = a; bus_rd = !wr; bus_wr = wr;
      @(negedge clk);
      check(req, {31'd0, bus_ack}, {31'd0, exp_hit});
      if (exp_hit && !wr) check(req, {16'd0, bus_rdata}, {16'd0, exp_d});
      @(negedge clk);
      check({req, " hold"}, {31'd0, bus_ack}, {31'd0, exp_hit});
      bus_rd = 1'b0; bus_wr = 1'b0;
      @(negedge clk);
      check({req, " release"}, {31'd0, bus_ack}, 32'd0);
   endtask

   task automatic power_up();
      @(negedge clk); bus_init = 1'b1;
      repeat (2) @(negedge clk);
      bus_init = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 ack in reset", {31'd0, bus_ack}, 32'd0);
      check("R1 data in reset", {16'd0, bus_rdata}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 ack after reset", {31'd0, bus_ack}, 32'd0);
      cfg_boot_sw = 1'b1;
      access("R1 vector during init", 18'o000024, 1'b0, 1'b0, 16'd0);

      // R7 on-board switch, main target
      cfg_sw = 9'h155;
      bus_init = 1'b0;
      repeat (2) @(negedge clk);
      access("R7 pc main", 18'o000024, 1'b0, 1'b1, exp_rom(266));
      access("R3 sw while armed", 18'o773024, 1'b0, 1'b1, 16'h02AA);
      access("R7 psw main", 18'o000027, 1'b0, 1'b1, exp_rom(267));
      // R9 redirect over
      access("R9 pc after psw", 18'o000024, 1'b0, 1'b0, 16'd0);
      access("R9 psw after psw", 18'o000026, 1'b0, 1'b0, 16'd0);
      access("R3 sw after redirect", 18'o773024, 1'b0, 1'b1, 16'h02AA);

      // R10 rearm, R7 external line and alternate target
      cfg_boot_sw = 1'b0; cfg_boot_ext = 1'b1; cfg_alt_vec = 1'b1;
      power_up();
      access("R7 pc alt", 18'o000024, 1'b0, 1'b1, exp_rom(330));
      access("R7 psw alt", 18'o000026, 1'b0, 1'b1, exp_rom(331));
      // R10 init cancels a pending redirect
      power_up();
      @(negedge clk); bus_init = 1'b1;
      @(negedge clk); cfg_boot_ext = 1'b0;
      access("R10 pc after cancel", 18'o000024, 1'b0, 1'b0, 16'd0);
      bus_init = 1'b0;
      repeat (2) @(negedge clk);

      // R8 no enable
      cfg_alt_vec = 1'b0;
      power_up();
      access("R8 pc unclaimed", 18'o000024, 1'b0, 1'b0, 16'd0);
      access("R8 psw unclaimed", 18'o000026, 1'b0, 1'b0, 16'd0);

      // R2 full sweep of both windows
      for (int k = 0; k < 256; k++) begin
         access("R2 low window", 18'o765000 + 18'(2*k + (k % 2)), 1'b0, 1'b1, exp_rom(k));
      end
      for (int k = 0; k < 256; k++) begin
         if (k == 10)
            access("R3 sw in window", 18'o773024, 1'b0, 1'b1, 16'h02AA);
         else
            access("R2 high window", 18'o773000 + 18'(2*k + (k % 2)), 1'b0, 1'b1, exp_rom(256 + k));
      end

      // R3 switch patterns
      for (int s = 0; s < 3; s++) begin
         logic [8:0] v;
         v = (s == 0) ? 9'h1FF : (s == 1) ? 9'h000 : 9'h0A3;
         cfg_sw = v;
         access("R3 sw pattern", 18'o773025, 1'b0, 1'b1, {6'd0, v, 1'b0});
      end

      // R4 low window disabled
      cfg_lo_off = 1'b1;
      for (int k = 0; k < 256; k++) begin
         access("R4 low off", 18'o765000 + 18'(2*k), k[0], 1'b0, 16'd0);
      end
      access("R4 high still served", 18'o773000, 1'b0, 1'b1, exp_rom(256));
      cfg_lo_off = 1'b0;

      // R5 undecoded addresses
      access("R5 undecoded 0", 18'o000000, 1'b0, 1'b0, 16'd0);
      access("R5 undecoded below lo", 18'o764776, 1'b0, 1'b0, 16'd0);
      access("R5 undecoded above lo", 18'o766000, 1'b0, 1'b0, 16'd0);
      access("R5 undecoded below hi", 18'o772776, 1'b0, 1'b0, 16'd0);
      access("R5 undecoded above hi", 18'o774000, 1'b0, 1'b0, 16'd0);
      access("R5 undecoded top", 18'o777776, 1'b0, 1'b0, 16'd0);

      // R6 writes acknowledged and ignored
      access("R6 write low", 18'o765000, 1'b1, 1'b1, 16'd0);
      access("R6 read back low", 18'o765000, 1'b0, 1'b1, exp_rom(0));
      access("R6 write high", 18'o773100, 1'b1, 1'b1, 16'd0);
      access("R6 read back high", 18'o773100, 1'b0, 1'b1, exp_rom(256 + 32));
      access("R6 write sw", 18'o773024, 1'b1, 1'b1, 16'd0);
      access("R6 read back sw", 18'o773024, 1'b0, 1'b1, 16'h0146);
      access("R6 write undecoded", 18'o001000, 1'b1, 1'b0, 16'd0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule